// File: doc/BRIEF.md
# Duplicated-Bit Parity Link Codec

This block protects a parallel wire bundle between two network switches against a single faulty wire. On the send side, a K-bit word is spread over 2K+1 wires. Each data bit drives two neighbouring wires, and one extra wire carries the even parity of the word. Because the two wires of a pair always carry the same value, neighbouring wires inside a pair never switch in opposite directions. This limits the worst-case coupling load on any wire to (1+2λ)CL.

On the receive side, the decoder takes the XOR of the first copy of every bit and compares it with the received parity wire. If they match, it forwards the first copy. If they differ, it forwards the second copy and raises a flag. Any single flipped wire therefore produces the original word. The block contains one encode path and one decode path. A parameter selects whether both paths end in a register stage, so the codec can sit inside an existing link pipeline stage, or stay purely combinational.

Top module: `dap_link_codec`

## Requirements
- R1: For data width K (default 32), `tx_code` is 2K+1 bits wide. Wire 2i and wire 2i+1 both carry data bit i, for i from 0 to K-1.
- R2: Wire 2K of `tx_code` carries the XOR of all K data bits (even parity).
- R3: In every emitted code word, wire 2i equals wire 2i+1 for every i. Neighbouring wires of a pair therefore never make opposite transitions.
- R4: A received word with no wire in error produces `rx_data` equal to the sent data, with `rx_alt_sel` low.
- R5: A single error on a first-copy wire (an even index below 2K) produces the correct `rx_data`, with `rx_alt_sel` high.
- R6: A single error on a second-copy wire (an odd index) produces the correct `rx_data`, with `rx_alt_sel` low.
- R7: A single error on the parity wire (index 2K) produces the correct `rx_data`, with `rx_alt_sel` high.
- R8: With REG_OUT=1 (the default), `tx_code`, `rx_data` and `rx_alt_sel` change only at a rising clock edge. Each reflects the inputs sampled at that edge, so the latency is one cycle. With REG_OUT=0, the paths are combinational.
- R9: While `rst_n` is low at a rising edge, the registered `tx_code`, `rx_data` and `rx_alt_sel` are cleared to zero (synchronous, active-low).
- R10: For any received word, including words with several errors, `rx_alt_sel` is high exactly when the XOR of the first copies differs from the parity wire. `rx_data` is the second copy in that case and the first copy otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | K | Word to send over the link |
| tx_code | output | 2K+1 | Encoded wires: duplicated pairs, parity on top |
| rx_code | input | 2K+1 | Wires received from the link |
| rx_data | output | K | Corrected word |
| rx_alt_sel | output | 1 | High when the second copy was forwarded |

## Verification
The bench flips every wire position of the received word in turn. It checks that an even-indexed fault and a parity fault both switch selection to the second copy, and that an odd-indexed fault leaves the first copy in use. A decoder that swapped the mux sense, or computed parity over the wrong copy, would pass error-free traffic but return corrupted words on exactly these positions.

Two-wire faults pin down the exact selection rule, including the case of both copies of one bit flipped. An inverted parity convention would fail already on the all-zero and all-one words. An output that leaked through combinationally would be caught by sampling just after the inputs change. A reset that was asynchronous or incomplete would be caught by the mid-run reset check.

// File: rtl/dap_link_pkg.sv
// Shared definitions for the duplicated-bit parity link codec.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dap_link_pkg;

    // Which of the two received copies the decoder forwarded.
    typedef enum logic {
        COPY_FIRST  = 1'b0,
        COPY_SECOND = 1'b1
    } copy_sel_e;

    // Number of link wires needed for a data width.
    function automatic int unsigned link_width(input int unsigned data_w);
        return 2 * data_w + 1;
    endfunction

endpackage

// File: rtl/dap_encoder.sv
// Encoder: places every data bit on two neighbouring wires (2i, 2i+1)
// and the even parity of the word on the top wire (2K).
// Assumes: DATA_W >= 1; purely combinational.
module dap_encoder #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CODE_W = dap_link_pkg::link_width(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    // Duplicate each bit onto an adjacent wire pair.
    for (genvar i = 0; i < DATA_W; i++) begin : g_pair
        assign code_o[2*i]   = data_i[i];
        assign code_o[2*i+1] = data_i[i];
    end

    // Parity wire sits above all pairs.
    assign code_o[CODE_W-1] = ^data_i;

endmodule

// File: rtl/dap_decoder.sv
// Decoder: recomputes parity over the first copies. On a match it forwards
// the first copies; otherwise it forwards the second copies and reports it.
// Assumes: wire order produced by dap_encoder; purely combinational.
module dap_decoder #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CODE_W = dap_link_pkg::link_width(DATA_W)
) (
    input  logic [CODE_W-1:0]       code_i,
    output logic [DATA_W-1:0]       data_o,
    output dap_link_pkg::copy_sel_e sel_o
);
    import dap_link_pkg::*;

    logic [DATA_W-1:0] first_copy;
    logic [DATA_W-1:0] second_copy;
    logic              parity_rx;
    logic              parity_calc;

    // Split the interleaved wires back into two words.
    for (genvar i = 0; i < DATA_W; i++) begin : g_split
        assign first_copy[i]  = code_i[2*i];
        assign second_copy[i] = code_i[2*i+1];
    end

    assign parity_rx   = code_i[CODE_W-1];
    assign parity_calc = ^first_copy;

    // Choose the copy whose consistency the parity wire confirms.
    always_comb begin
        if (parity_calc == parity_rx) begin
            sel_o  = COPY_FIRST;
            data_o = first_copy;
        end else begin
            sel_o  = COPY_SECOND;
            data_o = second_copy;
        end
    end

endmodule

// File: rtl/dap_out_stage.sv
// Optional pipeline stage: a register with synchronous active-low reset
// when REGISTERED=1, a plain feed-through when REGISTERED=0.
// Assumes: clk and rst_n are only used in the registered variant.
module dap_out_stage #(
    parameter int unsigned WIDTH      = 8,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    if (REGISTERED) begin : g_reg
        // Capture the stage input each cycle; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o <= '0;
            end else begin
                q_o <= d_i;
            end
        end
    end else begin : g_comb
        assign q_o = d_i;
    end

endmodule

// File: rtl/dap_link_codec.sv
// Top of the duplicated-bit parity link codec: one encode path for the
// sending side and one decode path for the receiving side, each ending in
// an optional register stage so it can merge into a link pipeline stage.
// Assumes: a single clock domain; rst_n is synchronous and active low.
module dap_link_codec #(
    parameter int unsigned DATA_W  = 32,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned CODE_W = dap_link_pkg::link_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    output logic [CODE_W-1:0] tx_code,
    input  logic [CODE_W-1:0] rx_code,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_alt_sel
);
    import dap_link_pkg::*;

    logic [CODE_W-1:0] enc_code;
    logic [DATA_W-1:0] dec_data;
    copy_sel_e         dec_sel;
    logic [DATA_W:0]   rx_stage_d;
    logic [DATA_W:0]   rx_stage_q;

    dap_encoder #(.DATA_W(DATA_W)) enc_i (
        .data_i (tx_data),
        .code_o (enc_code)
    );

    dap_decoder #(.DATA_W(DATA_W)) dec_i (
        .code_i (rx_code),
        .data_o (dec_data),
        .sel_o  (dec_sel)
    );

    dap_out_stage #(.WIDTH(CODE_W), .REGISTERED(REG_OUT)) tx_stage_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (enc_code),
        .q_o   (tx_code)
    );

    // Pack flag and word so both leave through one stage.
    assign rx_stage_d = {dec_sel == COPY_SECOND, dec_data};

    dap_out_stage #(.WIDTH(DATA_W + 1), .REGISTERED(REG_OUT)) rx_stage_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_stage_d),
        .q_o   (rx_stage_q)
    );

    assign rx_data    = rx_stage_q[DATA_W-1:0];
    assign rx_alt_sel = rx_stage_q[DATA_W];

    // ---------------- assertions ----------------
    logic [DATA_W-1:0] tx_first, tx_second, rx_first, rx_second;

    for (genvar i = 0; i < DATA_W; i++) begin : g_chk_split
        assign tx_first[i]  = tx_code[2*i];
        assign tx_second[i] = tx_code[2*i+1];
        assign rx_first[i]  = rx_code[2*i];
        assign rx_second[i] = rx_code[2*i+1];
    end

    logic seen_rst;

    // Remember that a reset has been applied, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst <= 1'b1;
        end
    end

    if (REG_OUT) begin : g_reg_chk
        // R9
        rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_rst && $past(!rst_n)) |->
            (tx_code == '0 && rx_data == '0 && !rx_alt_sel));

        // R1
        tx_pairs_carry_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_rst && $past(rst_n)) |-> (tx_first == $past(tx_data)));

        // R2
        tx_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_rst && $past(rst_n)) |-> (tx_code[CODE_W-1] == ^$past(tx_data)));

        // R3
        tx_pair_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_rst |-> (tx_first == tx_second));

        // R4
        clean_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_rst && $past(rst_n) &&
             $past(rx_first == rx_second && (^rx_first) == rx_code[CODE_W-1])) |->
            (rx_data == $past(rx_first) && !rx_alt_sel));

        // R7
        parity_wire_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_rst && $past(rst_n) &&
             $past(rx_first == rx_second && (^rx_first) != rx_code[CODE_W-1])) |->
            (rx_data == $past(rx_first) && rx_alt_sel));
    end

endmodule

// File: tb/dap_link_codec_tb.sv
`timescale 1ns/1ps
module dap_link_codec_tb_top;
    localparam int K = 32;
    localparam int W = 2 * K + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [K-1:0] tx_data = '0;
    logic [W-1:0] tx_code;
    logic [W-1:0] rx_code = '0;
    logic [K-1:0] rx_data;
    logic         rx_alt_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [W-1:0] prev_tx_exp = '0;
    logic [K-1:0] prev_rx_exp = '0;
    logic         prev_f_exp  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dap_link_codec #(.DATA_W(K), .REG_OUT(1'b1)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_code    (tx_code),
        .rx_code    (rx_code),
        .rx_data    (rx_data),
        .rx_alt_sel (rx_alt_sel)
    );

    // Behavioural model of the wire layout from the requirements.
    function automatic logic [W-1:0] ref_encode(input logic [K-1:0] d);
        logic [W-1:0] c = '0;
        int ones = 0;
        for (int i = 0; i < K; i++) begin
            c[2*i]   = d[i];
            c[2*i+1] = d[i];
            if (d[i]) ones++;
        end
        c[W-1] = (ones % 2 == 1);
        return c;
    endfunction

    task automatic check_eq(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; confirm outputs hold until the next rising
    // edge (R8), then compare at the following falling edge.
    task automatic step(input logic [K-1:0] d, input logic [W-1:0] rc,
                        input logic [K-1:0] exp_d, input logic exp_f, input string req);
        tx_data = d;
        rx_code = rc;
        #1;
        check_eq("R8 tx hold", {63'b0, tx_code}, {63'b0, prev_tx_exp});
        check_eq("R8 rx hold", {95'b0, rx_alt_sel, rx_data}, {95'b0, prev_f_exp, prev_rx_exp});
        @(negedge clk);
        check_eq("R1 R2 R3 encode", {63'b0, tx_code}, {63'b0, ref_encode(d)});
        check_eq(req, {95'b0, rx_alt_sel, rx_data}, {95'b0, exp_f, exp_d});
        prev_tx_exp = ref_encode(d);
        prev_rx_exp = exp_d;
        prev_f_exp  = exp_f;
    endtask

    initial begin
        logic [K-1:0] v;
        logic [W-1:0] c;
        int pos;
        // R9: reset clears every registered output
        tx_data = '1;
        rx_code = '1;
        repeat (3) @(negedge clk);
        check_eq("R9 reset", {62'b0, tx_code, rx_alt_sel, rx_data},
                 {62'b0, {W{1'b0}}, 1'b0, {K{1'b0}}});
        rst_n = 1'b1;
        tx_data = '0;
        rx_code = '0;
        @(negedge clk);

        // R4: clean words, several patterns
        step('0, ref_encode('0), '0, 1'b0, "R4 zero");
        step('1, ref_encode('1), '1, 1'b0, "R4 ones");
        step(32'hA5A5_5A5A, ref_encode(32'hA5A5_5A5A), 32'hA5A5_5A5A, 1'b0, "R4 mixed");
        step(32'h0000_0001, ref_encode(32'h0000_0001), 32'h0000_0001, 1'b0, "R4 odd weight");

        // R5/R6/R7: every single-wire fault position
        v = 32'h1357_9BDF;
        for (int n = 0; n < 2 * W; n++) begin
            pos = n % W;
            v = v * 32'd1103515245 + 32'd12345;
            c = ref_encode(v);
            c[pos] = ~c[pos];
            if (pos == W - 1)
                step(v, c, v, 1'b1, "R7 parity wire fault");
            else if (pos % 2 == 0)
                step(v, c, v, 1'b1, "R5 first copy fault");
            else
                step(v, c, v, 1'b0, "R6 second copy fault");
        end

        // R10: two faults in first copies keep parity; first copy forwarded
        v = 32'hCAFE_F00D;
        c = ref_encode(v);
        c[6] = ~c[6];
        c[34] = ~c[34];
        step(v, c, v ^ 32'h0002_0008, 1'b0, "R10 two first-copy faults");

        // R10: both copies of bit 5 flipped; second copy forwarded
        c = ref_encode(v);
        c[10] = ~c[10];
        c[11] = ~c[11];
        step(v, c, v ^ 32'h0000_0020, 1'b1, "R10 both copies of one bit");

        // R10: first-copy fault plus parity fault; parity agrees, first copy wins
        c = ref_encode(v);
        c[0] = ~c[0];
        c[W-1] = ~c[W-1];
        step(v, c, v ^ 32'h1, 1'b0, "R10 first copy plus parity");

        // R9: reset in mid-run clears outputs synchronously
        rst_n = 1'b0;
        tx_data = '1;
        rx_code = ref_encode('1);
        @(negedge clk);
        check_eq("R9 mid-run reset", {62'b0, tx_code, rx_alt_sel, rx_data},
                 {62'b0, {W{1'b0}}, 1'b0, {K{1'b0}}});
        rst_n = 1'b1;
        prev_tx_exp = '0;
        prev_rx_exp = '0;
        prev_f_exp  = 1'b0;
        step(32'h8000_0000, ref_encode(32'h8000_0000), 32'h8000_0000, 1'b0, "R4 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule